// File: doc/BRIEF.md
# Radio Transceiver State Controller

This block is the operating-state sequencer of a low-rate 2.4 GHz packet transceiver. A host writes 5-bit commands into a command register. A multi-purpose pin either starts a transmission or asks for sleep, depending on the current state. Strobes from the receive and transmit datapaths mark frame boundaries. A PLL-lock input and a regulator-ready input gate the slow analog transitions. The block reports its current state as a 5-bit status code.

After power-on the block holds until a start-up timer has expired and the regulators report ready. Moving from off into any state that needs the PLL passes through a settle phase, which has its own status code. Receive is split into a listen state and a busy state, for plain listening and for auto-acknowledge listening alike. Transmit works the same way from the PLL-on state and from the auto-retry state.

There are two off commands. One abandons a frame in flight at once. The other is remembered and takes effect when the frame ends. A synchronous soft reset returns the block to off from anywhere except power-on.

Top module: `trx_state_ctrl`

## Requirements
- R1: Command codes are 0 no-op, 2 transmit start, 3 forced off, 6 receive listen, 8 off, 9 PLL on, 22 auto-acknowledge listen and 25 auto-retry transmit. A write of a listed code shows in `cmdReg` after the next clock edge.
- R2: Any unlisted command code behaves as no-op. `cmdReg` reads 0 afterwards and the state does not change.
- R3: After `rstN` is released, status is 0x00 (power-on) and `cmdReg` is 0. Commands are ignored in this state. Status changes to off (0x08) on the first edge at which STARTUP_CYCLES edges have passed and `regOk` is high.
- R4: In off, codes 6, 9, 22 and 25 move the block to settle (0x1F). It leaves settle after SETTLE_CYCLES edges, and not before `pllLock` is high, into 0x06, 0x09, 0x16 or 0x19 respectively.
- R5: `rxFrameStart` moves listen 0x06 to 0x01 and listen 0x16 to 0x11. `rxFrameEnd` returns each busy state to its own listen state.
- R6: In 0x09 or 0x19, a transmit-start command or a rising edge on `sleepTxPin` moves the block to 0x02 or 0x12 respectively. `txFrameEnd` returns it to 0x09 or 0x19. A pin held high gives no second start.
- R7: A forced off (code 3) in any busy state (0x01, 0x02, 0x11, 0x12) moves the block to 0x08 on the next edge.
- R8: An off (code 8) in a busy state keeps that busy state. The block moves to 0x08 on the frame-end strobe.
- R9: Code 3 or code 8 in a listen state, in a PLL-on state or in settle moves the block to 0x08 on the next edge.
- R10: Codes 6, 9, 22 and 25 in any of 0x06, 0x09, 0x16 or 0x19 switch directly to the named state on the next edge, with no settle phase.
- R11: `sleepTxPin` high in off moves the block to sleep (0x0F). Commands are ignored in sleep. The pin going low returns the block to 0x08.
- R12: `softRst` moves any state except power-on to 0x08 and clears `cmdReg` and any pending off. It has no effect in power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| softRst | input | 1 | Synchronous return to off |
| cmdWrEn | input | 1 | Command write strobe |
| cmdIn | input | 5 | Command code written |
| sleepTxPin | input | 1 | Sleep request in off; transmit start in PLL-on states |
| rxFrameStart | input | 1 | Receive datapath frame-start strobe |
| rxFrameEnd | input | 1 | Receive datapath frame-end strobe |
| txFrameEnd | input | 1 | Transmit datapath frame-end strobe |
| pllLock | input | 1 | PLL lock indication |
| regOk | input | 1 | Regulators settled |
| statusCode | output | 5 | Current state code |
| cmdReg | output | 5 | Command register readback |

## Verification
A wrong state register shows on `statusCode` one edge after the stimulus that should have moved it, because the status is decoded directly from that register. A lost or spurious pending-off flag shows only at the next frame end, as either a return to listen or a drop to off. The bench therefore checks the status both before and after each frame-end strobe. A settle counter that is off by one moves the edge at which the destination code appears, so the settle and start-up windows are sampled on both sides of the expected edge.

// File: rtl/trx_ctrl_pkg.sv
package trx_ctrl_pkg;

  typedef enum logic [4:0] {
    CMD_NOP      = 5'd0,
    CMD_TX_START = 5'd2,
    CMD_FORCE    = 5'd3,
    CMD_RX_ON    = 5'd6,
    CMD_OFF      = 5'd8,
    CMD_PLL_ON   = 5'd9,
    CMD_RX_AACK  = 5'd22,
    CMD_TX_ARET  = 5'd25
  } cmd_e;

  // state encoding doubles as the visible status code
  typedef enum logic [4:0] {
    ST_P_ON         = 5'h00,
    ST_BUSY_RX      = 5'h01,
    ST_BUSY_TX      = 5'h02,
    ST_RX_ON        = 5'h06,
    ST_OFF          = 5'h08,
    ST_PLL_ON       = 5'h09,
    ST_SLEEP        = 5'h0F,
    ST_BUSY_RX_AACK = 5'h11,
    ST_BUSY_TX_ARET = 5'h12,
    ST_RX_AACK_ON   = 5'h16,
    ST_TX_ARET_ON   = 5'h19,
    ST_SETTLE       = 5'h1F
  } state_e;

  typedef struct packed {
    logic loadSettle;
    logic clrCmd;
  } ctrlStrobe_t;

  typedef struct packed {
    logic cntZero;
    logic pinLevel;
    logic pinRise;
    logic cmdValid;
    cmd_e cmd;
  } dpStatus_t;

  function automatic cmd_e foldCmd(input logic [4:0] code);
    case (code)
      5'd2:    return CMD_TX_START;
      5'd3:    return CMD_FORCE;
      5'd6:    return CMD_RX_ON;
      5'd8:    return CMD_OFF;
      5'd9:    return CMD_PLL_ON;
      5'd22:   return CMD_RX_AACK;
      5'd25:   return CMD_TX_ARET;
      default: return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/trx_ctrl_dp.sv
module trx_ctrl_dp
  import trx_ctrl_pkg::*;
#(
  parameter int STARTUP_CYCLES = 4096,
  parameter int SETTLE_CYCLES  = 1760
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        cmdWrEn,
  input  logic [4:0]  cmdIn,
  input  logic        sleepTxPin,
  output dpStatus_t   dp,
  output logic [4:0]  cmdReg
);

  localparam int MAX_CYC = (STARTUP_CYCLES > SETTLE_CYCLES) ? STARTUP_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  logic [CNT_W-1:0] cnt;
  logic             pinQ;

  // shared wait counter: start-up window at reset, settle window on request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_W'(STARTUP_CYCLES - 1);
    end else if (strobe.loadSettle) begin
      cnt <= CNT_W'(SETTLE_CYCLES - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ   <= 1'b0;
      cmdReg <= 5'd0;
    end else begin
      pinQ <= sleepTxPin;
      if (strobe.clrCmd) begin
        cmdReg <= 5'd0;
      end else if (cmdWrEn) begin
        cmdReg <= foldCmd(cmdIn);
      end
    end
  end

  always_comb begin
    dp.cntZero  = (cnt == '0);
    dp.pinLevel = sleepTxPin;
    dp.pinRise  = sleepTxPin & ~pinQ;
    dp.cmdValid = cmdWrEn;
    dp.cmd      = foldCmd(cmdIn);
  end

  a_r2_undef_reads_nop: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !strobe.clrCmd &&
     !(cmdIn inside {5'd0, 5'd2, 5'd3, 5'd6, 5'd8, 5'd9, 5'd22, 5'd25}))
    |=> cmdReg == 5'd0);

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && !strobe.loadSettle) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/trx_ctrl_fsm.sv
module trx_ctrl_fsm
  import trx_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  dpStatus_t   dp,
  input  logic        rxFrameStart,
  input  logic        rxFrameEnd,
  input  logic        txFrameEnd,
  input  logic        pllLock,
  input  logic        regOk,
  output state_e      stateQ,
  output ctrlStrobe_t strobe
);

  state_e stateD, targetQ, targetD;
  logic   pendOffQ, pendOffD;
  logic   forceCmd, softOffCmd, offCmd, pllCmd, txCmd;

  function automatic state_e idleOf(input cmd_e c);
    case (c)
      CMD_RX_ON:   return ST_RX_ON;
      CMD_PLL_ON:  return ST_PLL_ON;
      CMD_RX_AACK: return ST_RX_AACK_ON;
      default:     return ST_TX_ARET_ON;
    endcase
  endfunction

  function automatic logic isBusy(input state_e s);
    return (s == ST_BUSY_RX) || (s == ST_BUSY_TX) ||
           (s == ST_BUSY_RX_AACK) || (s == ST_BUSY_TX_ARET);
  endfunction

  always_comb begin
    forceCmd   = dp.cmdValid && (dp.cmd == CMD_FORCE);
    softOffCmd = dp.cmdValid && (dp.cmd == CMD_OFF);
    offCmd     = forceCmd || softOffCmd;
    pllCmd     = dp.cmdValid && (dp.cmd inside {CMD_RX_ON, CMD_PLL_ON, CMD_RX_AACK, CMD_TX_ARET});
    txCmd      = dp.cmdValid && (dp.cmd == CMD_TX_START);
  end

  always_comb begin
    stateD   = stateQ;
    targetD  = targetQ;
    pendOffD = pendOffQ;
    strobe   = '0;
    case (stateQ)
      ST_P_ON: begin
        if (dp.cntZero && regOk) stateD = ST_OFF;
      end
      ST_SLEEP: begin
        if (!dp.pinLevel) stateD = ST_OFF;
      end
      ST_OFF: begin
        if (pllCmd) begin
          stateD            = ST_SETTLE;
          targetD           = idleOf(dp.cmd);
          strobe.loadSettle = 1'b1;
        end else if (dp.pinLevel) begin
          stateD = ST_SLEEP;
        end
      end
      ST_SETTLE: begin
        if (offCmd) stateD = ST_OFF;
        else if (dp.cntZero && pllLock) stateD = targetQ;
      end
      ST_RX_ON, ST_RX_AACK_ON: begin
        if (offCmd) stateD = ST_OFF;
        else if (rxFrameStart) stateD = (stateQ == ST_RX_ON) ? ST_BUSY_RX : ST_BUSY_RX_AACK;
        else if (pllCmd) stateD = idleOf(dp.cmd);
      end
      ST_PLL_ON, ST_TX_ARET_ON: begin
        if (offCmd) stateD = ST_OFF;
        else if (txCmd || dp.pinRise) stateD = (stateQ == ST_PLL_ON) ? ST_BUSY_TX : ST_BUSY_TX_ARET;
        else if (pllCmd) stateD = idleOf(dp.cmd);
      end
      ST_BUSY_RX, ST_BUSY_RX_AACK: begin
        if (forceCmd) stateD = ST_OFF;
        else if (rxFrameEnd) begin
          if (pendOffQ || softOffCmd) stateD = ST_OFF;
          else stateD = (stateQ == ST_BUSY_RX) ? ST_RX_ON : ST_RX_AACK_ON;
        end else if (softOffCmd) pendOffD = 1'b1;
      end
      ST_BUSY_TX, ST_BUSY_TX_ARET: begin
        if (forceCmd) stateD = ST_OFF;
        else if (txFrameEnd) begin
          if (pendOffQ || softOffCmd) stateD = ST_OFF;
          else stateD = (stateQ == ST_BUSY_TX) ? ST_PLL_ON : ST_TX_ARET_ON;
        end else if (softOffCmd) pendOffD = 1'b1;
      end
      default: stateD = ST_OFF;
    endcase
    if (softRst && stateQ != ST_P_ON) begin
      stateD        = ST_OFF;
      strobe.clrCmd = 1'b1;
    end
    if (stateD == ST_OFF) pendOffD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_P_ON;
      targetQ  <= ST_OFF;
      pendOffQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      targetQ  <= targetD;
      pendOffQ <= pendOffD;
    end
  end

  a_r3_por_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_P_ON && !regOk) |=> stateQ == ST_P_ON);

  a_r4_settle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SETTLE && !pllLock && !offCmd && !softRst) |=> stateQ == ST_SETTLE);

  a_r7_force_abort: assert property (@(posedge clk) disable iff (!rstN)
    (isBusy(stateQ) && forceCmd) |=> stateQ == ST_OFF);

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BUSY_RX && !rxFrameEnd && !forceCmd && !softRst) |=> stateQ == ST_BUSY_RX);

  a_r11_wake: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP && !dp.pinLevel && !softRst) |=> stateQ == ST_OFF);

  a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && stateQ != ST_P_ON) |=> stateQ == ST_OFF);

endmodule

// File: rtl/trx_state_ctrl.sv
module trx_state_ctrl
  import trx_ctrl_pkg::*;
#(
  parameter int STARTUP_CYCLES = 4096,
  parameter int SETTLE_CYCLES  = 1760
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       cmdWrEn,
  input  logic [4:0] cmdIn,
  input  logic       sleepTxPin,
  input  logic       rxFrameStart,
  input  logic       rxFrameEnd,
  input  logic       txFrameEnd,
  input  logic       pllLock,
  input  logic       regOk,
  output logic [4:0] statusCode,
  output logic [4:0] cmdReg
);

  ctrlStrobe_t strobe;
  dpStatus_t   dp;
  state_e      stateQ;

  trx_ctrl_dp #(
    .STARTUP_CYCLES(STARTUP_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdWrEn   (cmdWrEn),
    .cmdIn     (cmdIn),
    .sleepTxPin(sleepTxPin),
    .dp        (dp),
    .cmdReg    (cmdReg)
  );

  trx_ctrl_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .softRst     (softRst),
    .dp          (dp),
    .rxFrameStart(rxFrameStart),
    .rxFrameEnd  (rxFrameEnd),
    .txFrameEnd  (txFrameEnd),
    .pllLock     (pllLock),
    .regOk       (regOk),
    .stateQ      (stateQ),
    .strobe      (strobe)
  );

  assign statusCode = stateQ;

endmodule

// File: tb/tb_trx_state_ctrl.sv
module tb_trx_state_ctrl;

  localparam int ST = 20;
  localparam int SE = 5;

  localparam logic [4:0] S_PON = 5'h00, S_BRX = 5'h01, S_BTX = 5'h02, S_RXON = 5'h06,
                         S_OFF = 5'h08, S_PLL = 5'h09, S_SLP = 5'h0F, S_BRXA = 5'h11,
                         S_BTXA = 5'h12, S_RXA = 5'h16, S_TXA = 5'h19, S_SET = 5'h1F;

  logic clk = 1'b0;
  logic rstN = 1'b0, softRst = 1'b0, cmdWrEn = 1'b0, sleepTxPin = 1'b0;
  logic rxFrameStart = 1'b0, rxFrameEnd = 1'b0, txFrameEnd = 1'b0;
  logic pllLock = 1'b1, regOk = 1'b0;
  logic [4:0] cmdIn = 5'd0;
  logic [4:0] statusCode, cmdReg;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  trx_state_ctrl #(.STARTUP_CYCLES(ST), .SETTLE_CYCLES(SE)) dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .cmdWrEn(cmdWrEn), .cmdIn(cmdIn),
    .sleepTxPin(sleepTxPin), .rxFrameStart(rxFrameStart), .rxFrameEnd(rxFrameEnd),
    .txFrameEnd(txFrameEnd), .pllLock(pllLock), .regOk(regOk),
    .statusCode(statusCode), .cmdReg(cmdReg)
  );

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic [4:0] c);
    cmdWrEn = 1'b1;
    cmdIn   = c;
    tick(1);
    cmdWrEn = 1'b0;
  endtask

  task automatic pulseRxStart(); rxFrameStart = 1'b1; tick(1); rxFrameStart = 1'b0; endtask
  task automatic pulseRxEnd();   rxFrameEnd   = 1'b1; tick(1); rxFrameEnd   = 1'b0; endtask
  task automatic pulseTxEnd();   txFrameEnd   = 1'b1; tick(1); txFrameEnd   = 1'b0; endtask

  function automatic logic [4:0] expReg(input logic [4:0] c);
    return (c inside {5'd0, 5'd2, 5'd3, 5'd6, 5'd8, 5'd9, 5'd22, 5'd25}) ? c : 5'd0;
  endfunction

  function automatic logic [4:0] expDest(input logic [4:0] c);
    case (c)
      5'd6:    return S_RXON;
      5'd9:    return S_PLL;
      5'd22:   return S_RXA;
      5'd25:   return S_TXA;
      default: return S_OFF;
    endcase
  endfunction

  task automatic settleTo(input logic [4:0] c);
    cmd(5'd3);
    cmd(c);
    tick(SE);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R3: power-on state and register value
    tick(3);
    chk("R3 status in reset", statusCode, S_PON);
    chk("R3 cmdReg in reset", cmdReg, 5'd0);
    rstN = 1'b1;
    tick(30);
    chk("R3 waits for regOk", statusCode, S_PON);
    softRst = 1'b1; tick(1); softRst = 1'b0;
    chk("R12 no effect in power-on", statusCode, S_PON);
    cmd(5'd6);
    chk("R3 command ignored in power-on", statusCode, S_PON);
    regOk = 1'b1;
    tick(1);
    chk("R3 off after regOk", statusCode, S_OFF);

    // R3: exact start-up window with regOk already high
    rstN = 1'b0; tick(1); rstN = 1'b1;
    tick(ST - 1);
    chk("R3 start-up edge minus one", statusCode, S_PON);
    tick(1);
    chk("R3 start-up edge", statusCode, S_OFF);

    // R1 R2 R4: sweep every command code from off
    for (int c = 0; c < 32; c++) begin
      cmd(5'd3);
      cmd(5'(c));
      chk("R1 R2 cmdReg readback", cmdReg, expReg(5'(c)));
      if (expDest(5'(c)) != S_OFF) begin
        chk("R4 settle code", statusCode, S_SET);
        tick(SE - 1);
        chk("R4 settle before expiry", statusCode, S_SET);
        tick(1);
        chk("R4 destination after settle", statusCode, expDest(5'(c)));
      end else begin
        chk("R2 no move from off", statusCode, S_OFF);
      end
    end

    // R4: lock gates the exit from settle
    cmd(5'd3);
    pllLock = 1'b0;
    cmd(5'd6);
    tick(SE + 3);
    chk("R4 held without lock", statusCode, S_SET);
    pllLock = 1'b1;
    tick(1);
    chk("R4 exit on lock", statusCode, S_RXON);

    // R2: undefined code in listen
    cmd(5'd7);
    chk("R2 listen unchanged", statusCode, S_RXON);
    chk("R2 cmdReg folded", cmdReg, 5'd0);

    // R5 and R8: listen/busy, pending off
    pulseRxStart();
    chk("R5 frame start", statusCode, S_BRX);
    pulseRxEnd();
    chk("R5 frame end", statusCode, S_RXON);
    pulseRxStart();
    cmd(5'd8);
    chk("R8 off pending in busy", statusCode, S_BRX);
    tick(3);
    chk("R8 still busy", statusCode, S_BRX);
    pulseRxEnd();
    chk("R8 off at frame end", statusCode, S_OFF);

    // R7: forced off aborts
    settleTo(5'd6);
    pulseRxStart();
    cmd(5'd3);
    chk("R7 forced off from busy rx", statusCode, S_OFF);

    // R6: transmit from PLL on
    settleTo(5'd9);
    chk("R4 pll on reached", statusCode, S_PLL);
    cmd(5'd2);
    chk("R6 tx start command", statusCode, S_BTX);
    pulseTxEnd();
    chk("R6 tx end", statusCode, S_PLL);
    sleepTxPin = 1'b1;
    tick(1);
    chk("R6 pin rise starts tx", statusCode, S_BTX);
    pulseTxEnd();
    tick(2);
    chk("R6 held pin no restart", statusCode, S_PLL);
    sleepTxPin = 1'b0;
    tick(1);
    cmd(5'd2);
    cmd(5'd3);
    chk("R7 forced off from busy tx", statusCode, S_OFF);

    // R10: direct switches and the auto modes
    settleTo(5'd9);
    cmd(5'd22);
    chk("R10 pll on to auto-ack listen", statusCode, S_RXA);
    pulseRxStart();
    chk("R5 auto-ack busy", statusCode, S_BRXA);
    pulseRxEnd();
    chk("R5 auto-ack back to listen", statusCode, S_RXA);
    cmd(5'd25);
    chk("R10 listen to auto-retry", statusCode, S_TXA);
    cmd(5'd2);
    chk("R6 auto-retry busy", statusCode, S_BTXA);
    pulseTxEnd();
    chk("R6 auto-retry idle", statusCode, S_TXA);
    cmd(5'd6);
    chk("R10 auto-retry to listen", statusCode, S_RXON);

    // R12: soft reset from busy with pending off
    cmd(5'd9);
    cmd(5'd2);
    cmd(5'd8);
    chk("R8 tx busy holds", statusCode, S_BTX);
    softRst = 1'b1; tick(1); softRst = 1'b0;
    chk("R12 soft reset to off", statusCode, S_OFF);
    chk("R12 cmdReg cleared", cmdReg, 5'd0);
    settleTo(5'd9);
    cmd(5'd2);
    pulseTxEnd();
    chk("R12 pending off cleared", statusCode, S_PLL);

    // R9: off commands outside busy
    cmd(5'd8);
    chk("R9 off from pll on", statusCode, S_OFF);
    cmd(5'd9);
    cmd(5'd8);
    chk("R9 off during settle", statusCode, S_OFF);
    settleTo(5'd22);
    cmd(5'd3);
    chk("R9 forced off from listen", statusCode, S_OFF);

    // R11: sleep and wake
    sleepTxPin = 1'b1;
    tick(1);
    chk("R11 sleep entry", statusCode, S_SLP);
    cmd(5'd6);
    tick(3);
    chk("R11 command ignored in sleep", statusCode, S_SLP);
    sleepTxPin = 1'b0;
    tick(1);
    chk("R11 wake to off", statusCode, S_OFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule